// File: doc/BRIEF.md
# Local Interrupt Countdown Timer

This block is a per-processor countdown timer that raises an interrupt request when its count runs out. Software talks to it over a small synchronous register bus. It programs a control word that holds the interrupt vector, a mask bit and a timer mode. It also sets a divide setting that scales the core clock down to the timer's tick rate. Writing a start value into the initial-count register launches the countdown. Software finds the elapsed ticks by subtracting the readable current count from the value it wrote.

When the count reaches zero and the timer is not masked, the block raises `irq_valid` and holds the programmed vector on `irq_vector`. Both stay until the consumer acknowledges with `irq_ack`. While the request waits, a status bit in the control word reads 1. In one-shot mode the timer then stops. In periodic mode it reloads its start value on the next tick and runs again. The deadline mode code and the spare mode code leave the counter frozen.

Top module: `local_countdown_timer`

## Requirements
- R1: After reset, `irq_valid` is 0. The control word (address 0) reads 0x0001_0000, which is masked, one-shot, vector 0. The initial count (address 1), the current count (address 2) and the divide setting (address 3) each read 0.
- R2: A write to address 1 loads the counter with the low COUNT_W bits of the write data. Address 1 reads back that truncated value. After the load the counter drops by one on each tick. Read data is registered: it shows the value the addressed register held just before the clock edge after the address is presented.
- R3: The divide setting at address 3 (bits 3:0) gives one tick every N core clocks. N is 2 to the power of ({bit3,bit1,bit0}+1) mod 8, so 1011 gives /1, 0000 /2, 0001 /4, 0010 /8, 0011 /16, 1000 /32, 1001 /64 and 1010 /128. Bit 2 is ignored for the ratio but reads back as written. A write to address 1 or address 3 restarts the prescaler.
- R4: One-shot mode is control bits 18:17 = 0. With a start value C, the count reaches zero and `irq_valid` rises C*N clock edges after the load edge. `irq_vector` equals control bits 7:0. The counter then stays at zero.
- R5: Periodic mode is control bits 18:17 = 1. On the tick after the count reaches zero, the counter reloads C. Successive requests are therefore (C+1)*N clocks apart.
- R6: When control bit 16 (mask) is 1, the counter still runs down to zero but `irq_valid` never rises.
- R7: Once raised, `irq_valid` holds until `irq_ack` is sampled high. It is low after that edge. Control bit 12 reads 1 while the request is pending and 0 otherwise.
- R8: Writing 0 to address 1 stops the timer. The current count reads 0 and no request follows.
- R9: With control bits 18:17 = 2 or 3, the counter holds its value and raises no request.
- R10: Writes to address 2 have no effect. In the control word, bit 12 and all bits other than 18:16 and 7:0 are ignored on write and read back as 0, except for the status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 2 | Register word address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data for the previous cycle's address |
| irq_valid | output | 1 | Interrupt request pending |
| irq_vector | output | 8 | Vector of the pending request |
| irq_ack | input | 1 | Consumer accepts the pending request |

## Verification
The bench builds the timer with COUNT_W = 12. This narrow counter lets a start value with bits above bit 11 show its truncation on readback. With the default width, that effect would stay out of sight. The prescaler keeps its full default range, so all eight ratios up to /128, plus a code with bit 2 set, are timed edge by edge with short start values. Periodic spacing, masking, the frozen modes and the stop-by-zero case all use start values of a few ticks, so every scenario stays short.

// File: rtl/lct_pkg.sv
`timescale 1ns/1ps
package lct_pkg;
    localparam int DATA_W    = 32;
    localparam int ADDR_W    = 2;
    localparam int VEC_W     = 8;
    localparam int DIV_W     = 4;
    localparam int SHIFT_W   = 3;
    localparam int B_STATUS  = 12;
    localparam int B_MASK    = 16;
    localparam int B_MODE_LO = 17;

    localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
    localparam logic [ADDR_W-1:0] A_INIT = 2'd1;
    localparam logic [ADDR_W-1:0] A_CURR = 2'd2;
    localparam logic [ADDR_W-1:0] A_DIV  = 2'd3;

    typedef enum logic [1:0] {
        MODE_ONCE     = 2'd0,
        MODE_REPEAT   = 2'd1,
        MODE_DEADLINE = 2'd2,
        MODE_SPARE    = 2'd3
    } tmode_e;

    typedef struct packed {
        logic [VEC_W-1:0] vector;
        logic             mask;
        tmode_e           mode;
    } tctl_t;

    // log2 of the divide ratio: {b3,b1,b0} plus one, wrapping at eight
    function automatic logic [SHIFT_W-1:0] div_shift(input logic [DIV_W-1:0] code);
        return {code[3], code[1:0]} + SHIFT_W'(1);
    endfunction
endpackage

// File: rtl/lct_regs.sv
`timescale 1ns/1ps
module lct_regs
    import lct_pkg::*;
#(
    parameter int COUNT_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_we,
    input  logic [DATA_W-1:0]  bus_wdata,
    input  logic [COUNT_W-1:0] cur_count,
    input  logic               pending,
    output tctl_t              ctl,
    output logic [DIV_W-1:0]   div_code,
    output logic               init_load,
    output logic [COUNT_W-1:0] init_val,
    output logic               pre_restart,
    output logic [DATA_W-1:0]  bus_rdata
);
    typedef struct packed {
        tctl_t              ctl;
        logic [DIV_W-1:0]   div;
        logic [COUNT_W-1:0] init;
        logic [DATA_W-1:0]  rdata;
    } regs_t;

    regs_t q, d;
    logic  wr_ctrl, wr_init, wr_div;
    logic [DATA_W-1:0] rd_word;

    always_comb begin
        wr_ctrl = bus_we && (bus_addr == A_CTRL);
        wr_init = bus_we && (bus_addr == A_INIT);
        wr_div  = bus_we && (bus_addr == A_DIV);

        rd_word = '0;
        unique case (bus_addr)
            A_CTRL: begin
                rd_word[VEC_W-1:0]             = q.ctl.vector;
                rd_word[B_STATUS]              = pending;
                rd_word[B_MASK]                = q.ctl.mask;
                rd_word[B_MODE_LO+1:B_MODE_LO] = q.ctl.mode;
            end
            A_INIT:  rd_word = DATA_W'(q.init);
            A_CURR:  rd_word = DATA_W'(cur_count);
            default: rd_word = DATA_W'(q.div);
        endcase

        d = q;
        d.rdata = rd_word;
        if (wr_ctrl) begin
            d.ctl.vector = bus_wdata[VEC_W-1:0];
            d.ctl.mask   = bus_wdata[B_MASK];
            d.ctl.mode   = tmode_e'(bus_wdata[B_MODE_LO+1:B_MODE_LO]);
        end
        if (wr_init) d.init = bus_wdata[COUNT_W-1:0];
        if (wr_div)  d.div  = bus_wdata[DIV_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.ctl.vector <= '0;
            q.ctl.mask   <= 1'b1;
            q.ctl.mode   <= MODE_ONCE;
            q.div        <= '0;
            q.init       <= '0;
            q.rdata      <= '0;
        end else begin
            q <= d;
        end
    end

    assign ctl         = q.ctl;
    assign div_code    = q.div;
    assign init_load   = wr_init;
    assign init_val    = bus_wdata[COUNT_W-1:0];
    assign pre_restart = wr_init || wr_div;
    assign bus_rdata   = q.rdata;

    // R10: a write to the current-count address leaves every stored field alone
    p_curr_write_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == A_CURR) |=> ($stable(q.ctl) && $stable(q.div) && $stable(q.init)));
endmodule

// File: rtl/lct_prescaler.sv
`timescale 1ns/1ps
module lct_prescaler
    import lct_pkg::*;
#(
    parameter int MAX_SHIFT = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [SHIFT_W-1:0] shift,
    input  logic               restart,
    output logic               tick
);
    localparam int PRE_W = MAX_SHIFT + 1;

    typedef struct packed {
        logic [PRE_W-1:0] pre;
    } pre_t;

    pre_t q, d;
    logic [PRE_W-1:0] last;

    always_comb begin
        last = (PRE_W'(1) << shift) - PRE_W'(1);
        tick = (q.pre == last) && !restart;
        d = q;
        if (restart || (q.pre == last)) d.pre = '0;
        else                            d.pre = q.pre + PRE_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R3: the phase never runs past the decoded ratio
    p_phase_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        q.pre <= last);

    // R3: a restart request puts the phase back to zero
    p_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (q.pre == '0));
endmodule

// File: rtl/lct_counter.sv
`timescale 1ns/1ps
module lct_counter
    import lct_pkg::*;
#(
    parameter int COUNT_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [COUNT_W-1:0] load_val,
    input  tmode_e             mode,
    input  logic               tick,
    output logic [COUNT_W-1:0] count,
    output logic               expire
);
    typedef struct packed {
        logic [COUNT_W-1:0] cnt;
        logic [COUNT_W-1:0] reload;
        logic               run;
    } cnt_t;

    cnt_t q, d;
    logic mode_live;

    always_comb begin
        mode_live = (mode == MODE_ONCE) || (mode == MODE_REPEAT);
        expire    = 1'b0;
        d         = q;
        if (load) begin
            d.cnt    = load_val;
            d.reload = load_val;
            d.run    = (load_val != '0);
        end else if (q.run && tick && mode_live) begin
            if (q.cnt == '0) begin
                if (mode == MODE_REPEAT) d.cnt = q.reload;
                else                     d.run = 1'b0;
            end else begin
                d.cnt = q.cnt - COUNT_W'(1);
                if (q.cnt == COUNT_W'(1)) begin
                    expire = 1'b1;
                    if (mode == MODE_ONCE) d.run = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign count = q.cnt;

    // R2: each tick while running takes exactly one off a count above one
    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && q.run && tick && mode_live && q.cnt > COUNT_W'(1))
        |=> (q.cnt == $past(q.cnt) - COUNT_W'(1)));

    // R4: a one-shot expiry leaves the counter idle at zero
    p_oneshot_stop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && mode == MODE_ONCE && !load) |=> (!q.run && q.cnt == '0));

    // R8: loading zero halts the counter
    p_zero_stops_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (load && load_val == '0) |=> (!q.run && q.cnt == '0));

    // R9: the frozen modes keep the count unchanged
    p_frozen_mode_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !mode_live) |=> $stable(q.cnt));
endmodule

// File: rtl/local_countdown_timer.sv
`timescale 1ns/1ps
module local_countdown_timer
    import lct_pkg::*;
#(
    parameter int COUNT_W   = 32,
    parameter int MAX_SHIFT = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_valid,
    output logic [VEC_W-1:0]  irq_vector,
    input  logic              irq_ack
);
    typedef struct packed {
        logic             pend;
        logic [VEC_W-1:0] vec;
    } irq_t;

    tctl_t              ctl;
    logic [DIV_W-1:0]   div_code;
    logic               init_load;
    logic [COUNT_W-1:0] init_val;
    logic               pre_restart;
    logic [COUNT_W-1:0] cur_count;
    logic               tick;
    logic               expire;
    irq_t               q, d;

    lct_regs #(.COUNT_W(COUNT_W)) i_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_addr   (bus_addr),
        .bus_we     (bus_we),
        .bus_wdata  (bus_wdata),
        .cur_count  (cur_count),
        .pending    (q.pend),
        .ctl        (ctl),
        .div_code   (div_code),
        .init_load  (init_load),
        .init_val   (init_val),
        .pre_restart(pre_restart),
        .bus_rdata  (bus_rdata)
    );

    lct_prescaler #(.MAX_SHIFT(MAX_SHIFT)) i_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .shift  (div_shift(div_code)),
        .restart(pre_restart),
        .tick   (tick)
    );

    lct_counter #(.COUNT_W(COUNT_W)) i_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (init_load),
        .load_val(init_val),
        .mode    (ctl.mode),
        .tick    (tick),
        .count   (cur_count),
        .expire  (expire)
    );

    always_comb begin
        d = q;
        if (q.pend && irq_ack) d.pend = 1'b0;
        if (expire && !ctl.mask) begin
            d.pend = 1'b1;
            d.vec  = ctl.vector;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign irq_valid  = q.pend;
    assign irq_vector = q.vec;

    // R7: a request waits until it is accepted
    p_irq_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_valid && !irq_ack) |=> irq_valid);

    // R7: acceptance drops the request when no new expiry coincides
    p_ack_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_valid && irq_ack && !expire) |=> !irq_valid);

    // R6: a request only appears after an unmasked expiry
    p_mask_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_valid) |-> $past(expire && !ctl.mask));
endmodule

// File: tb/test_local_countdown_timer.sv
`timescale 1ns/1ps
module test_local_countdown_timer;
    localparam int CW  = 12;
    localparam int LIM = 3000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_valid;
    logic [7:0]  irq_vector;
    logic        irq_ack = 1'b0;

    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    local_countdown_timer #(.COUNT_W(CW)) i_local_countdown_timer (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_valid(irq_valid),
        .irq_vector(irq_vector), .irq_ack(irq_ack)
    );

    task automatic check(input string req, input string what, input longint act, input longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] v);
        bus_addr = a; bus_wdata = v; bus_we = 1'b1;
        @(posedge clk); @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] v);
        bus_addr = a;
        @(posedge clk); @(negedge clk);
        v = bus_rdata;
    endtask

    task automatic ack();
        irq_ack = 1'b1;
        @(posedge clk); @(negedge clk);
        irq_ack = 1'b0;
    endtask

    task automatic wait_irq(output int k);
        k = 0;
        while (!irq_valid && k < LIM) begin
            @(negedge clk);
            k++;
        end
    endtask

    task automatic quiet(input int n, output int seen);
        seen = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (irq_valid) seen = 1;
        end
    endtask

    task automatic t_reset();
        logic [31:0] v;
        check("R1", "irq after reset", irq_valid, 0);
        rd(2'd0, v); check("R1", "control at reset", v, 32'h0001_0000);
        rd(2'd1, v); check("R1", "initial count at reset", v, 0);
        rd(2'd2, v); check("R1", "current count at reset", v, 0);
        rd(2'd3, v); check("R1", "divide at reset", v, 0);
    endtask

    task automatic t_oneshot();
        logic [31:0] v; int k; int s;
        wr(2'd3, 32'hB);
        wr(2'd0, 32'h0000_0041);
        wr(2'd1, 32'd5);
        wait_irq(k);
        check("R4", "one-shot latency", k, 5);
        check("R4", "vector", irq_vector, 8'h41);
        rd(2'd0, v); check("R7", "status bit while pending", v, 32'h0000_1041);
        quiet(3, s);
        check("R7", "request held without ack", irq_valid, 1);
        ack();
        check("R7", "request dropped after ack", irq_valid, 0);
        rd(2'd0, v); check("R7", "status bit after ack", v, 32'h0000_0041);
        quiet(12, s);
        check("R4", "no second one-shot request", s, 0);
        rd(2'd2, v); check("R4", "count stays at zero", v, 0);
    endtask

    task automatic t_load();
        logic [31:0] v; int s;
        wr(2'd3, 32'hB);
        wr(2'd0, 32'h0000_0007);
        wr(2'd1, 32'h0001_0040);
        rd(2'd2, v); check("R2", "count just after load", v, 32'h40);
        rd(2'd2, v); check("R2", "count one tick later", v, 32'h3F);
        rd(2'd1, v); check("R2", "truncated initial count", v, 32'h40);
        wr(2'd1, 32'd0);
        rd(2'd2, v); check("R8", "count after zero write", v, 0);
        quiet(100, s);
        check("R8", "no request after stop", s, 0);
        rd(2'd2, v); check("R8", "count stays stopped", v, 0);
    endtask

    task automatic t_divide();
        logic [3:0] codes [9] = '{4'hB, 4'h0, 4'h1, 4'h2, 4'h3, 4'h8, 4'h9, 4'hA, 4'h6};
        int ratios [9] = '{1, 2, 4, 8, 16, 32, 64, 128, 8};
        logic [31:0] v; int k;
        wr(2'd0, 32'h0000_0010);
        for (int i = 0; i < 9; i++) begin
            wr(2'd3, {28'd0, codes[i]});
            wr(2'd1, 32'd3);
            wait_irq(k);
            check("R3", $sformatf("latency for code %b", codes[i]), k, 3 * ratios[i]);
            ack();
        end
        rd(2'd3, v); check("R3", "divide readback keeps bit 2", v, 32'h6);
    endtask

    task automatic t_periodic();
        int k;
        wr(2'd3, 32'h0);
        wr(2'd0, 32'h0002_0022);
        wr(2'd1, 32'd4);
        wait_irq(k);
        check("R5", "first periodic expiry", k, 8);
        check("R5", "periodic vector", irq_vector, 8'h22);
        ack();
        wait_irq(k);
        check("R5", "second period", k, 9);
        ack();
        wait_irq(k);
        check("R5", "third period", k, 9);
        ack();
        wr(2'd1, 32'd0);
    endtask

    task automatic t_mask();
        logic [31:0] v; int s;
        wr(2'd3, 32'hB);
        wr(2'd0, 32'h0001_0033);
        wr(2'd1, 32'd6);
        quiet(20, s);
        check("R6", "masked expiry raises nothing", s, 0);
        rd(2'd2, v); check("R6", "masked counter still ran", v, 0);
    endtask

    task automatic t_frozen();
        logic [31:0] v; int s;
        wr(2'd3, 32'hB);
        wr(2'd0, 32'h0004_0055);
        wr(2'd1, 32'd9);
        quiet(30, s);
        check("R9", "mode 2 raises nothing", s, 0);
        rd(2'd2, v); check("R9", "mode 2 count frozen", v, 9);
        wr(2'd0, 32'h0006_0055);
        quiet(10, s);
        rd(2'd2, v); check("R9", "mode 3 count frozen", v, 9);
        wr(2'd1, 32'd0);
    endtask

    task automatic t_readonly();
        logic [31:0] v;
        wr(2'd2, 32'h123);
        rd(2'd2, v); check("R10", "current count ignores writes", v, 0);
        wr(2'd0, 32'h0003_1FAB);
        rd(2'd0, v); check("R10", "control ignores status and spare bits", v, 32'h0003_00AB);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_oneshot();
        t_load();
        t_divide();
        t_periodic();
        t_mask();
        t_frozen();
        t_readonly();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule